// File: doc/BRIEF.md
# Legacy-Mode Timer Interrupt Router

This block sits between a multi-channel event timer, a separate real-time clock and a 24-line interrupt controller input bank. In normal operation every timer channel drives the line selected by its own route field, and the clock's interrupt level passes straight through to its fixed line (line 8). Each output line is the OR of every source routed to it in that cycle.

A global legacy-replacement bit, written through a configuration strobe, changes this routing. While the bit is set, timer 0 is pinned to line 0 and timer 1 to line 8, and the clock interrupt is held off line 8 and flagged as masked. The clock level is recorded on every cycle whatever the mode, so when legacy mode is left, line 8 resumes with the clock's current recorded level and does not wait for a fresh edge. Each real change of the bit sends a one-cycle strobe to the legacy interval timer: disable on entry, enable on exit.

Top module: `legacy_irq_router`

## Requirements
- R1: With the legacy bit set, timer 0's request drives line 0 and no other line, regardless of its route field.
- R2: With the legacy bit set, timer 1's request drives line 8, regardless of its route field.
- R3: Timers 2 and above always, and all timers when the legacy bit is clear, drive the line equal to their 5-bit route field; a route value of 24 or more drives no line.
- R4: Each output line is the OR of all sources routed to it.
- R5: The clock level is recorded every cycle in either mode; with the legacy bit clear line 8 follows the recorded level, including right after legacy mode is left.
- R6: With the legacy bit set, the clock level does not reach line 8 and `rtc_masked_o` is 1; with it clear `rtc_masked_o` is 0.
- R7: A configuration write that changes the legacy bit from 0 to 1 produces a single-cycle `pit_disable_o` pulse, and line 8 drops the clock contribution in the same cycle.
- R8: A configuration write that changes the legacy bit from 1 to 0 produces a single-cycle `pit_enable_o` pulse.
- R9: A write of the value the bit already holds, or a cycle without a write, produces no strobe and leaves the mode unchanged.
- R10: All outputs reflect inputs sampled at the previous rising clock edge (one cycle of latency).
- R11: Reset clears the legacy bit, the recorded clock level, both strobes and all interrupt lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_legacy_i | input | 1 | Legacy bit value carried by the write |
| tmr_irq_i | input | NUM_TIMERS | Per-timer interrupt requests |
| tmr_route_i | input | NUM_TIMERS*ROUTE_W | Per-timer route fields, timer t at bits [t*ROUTE_W +: ROUTE_W] |
| rtc_level_i | input | 1 | Real-time clock interrupt level |
| irq_o | output | NUM_LINES | Interrupt output lines |
| legacy_o | output | 1 | Current legacy bit |
| rtc_masked_o | output | 1 | Clock interrupt is being masked |
| pit_disable_o | output | 1 | One-cycle disable strobe to the interval timer |
| pit_enable_o | output | 1 | One-cycle enable strobe to the interval timer |

## Verification
The bench aims at the clock level changing while legacy mode is active and then leaving the mode: a design that only forwarded edges, or stored the level only outside legacy mode, would leave line 8 stale instead of showing the current level. It writes the legacy bit twice with the same value, where edge detection on the write strobe instead of the value would fire spurious interval-timer strobes. It routes timer 0 to a non-zero line in legacy mode, which catches a design that ORs in the programmed route, and uses out-of-range routes and shared lines to catch wrap-around decoding and a lost OR term.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int unsigned DEF_NUM_TIMERS = 4;
  localparam int unsigned DEF_NUM_LINES  = 24;
  localparam int unsigned DEF_ROUTE_W    = 5;
  localparam int unsigned DEF_T0_LINE    = 0;
  localparam int unsigned DEF_T1_LINE    = 8;
  localparam int unsigned DEF_RTC_LINE   = 8;
endpackage

// File: rtl/lir_cfg_ctrl.sv
module lir_cfg_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_legacy_i,
  output logic legacy_d_o,
  output logic legacy_q_o,
  output logic pit_disable_o,
  output logic pit_enable_o
);
  logic legacy_q, dis_q, en_q;
  logic rise, fall;

  assign legacy_d_o = cfg_we_i ? cfg_legacy_i : legacy_q;
  // compare old and new value, not the strobe
  assign rise = cfg_we_i &  cfg_legacy_i & ~legacy_q;
  assign fall = cfg_we_i & ~cfg_legacy_i &  legacy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      legacy_q <= 1'b0;
      dis_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      legacy_q <= legacy_d_o;
      dis_q    <= rise;
      en_q     <= fall;
    end
  end

  assign legacy_q_o    = legacy_q;
  assign pit_disable_o = dis_q;
  assign pit_enable_o  = en_q;

  a_r7_disable_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_legacy_i && !legacy_q_o) |=> (pit_disable_o && legacy_q_o));
  a_r8_enable_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_legacy_i && legacy_q_o) |=> (pit_enable_o && !legacy_q_o));
  a_r9_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i || (cfg_legacy_i == legacy_q_o)) |=> (!pit_disable_o && !pit_enable_o && $stable(legacy_q_o)));
  a_r7_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pit_disable_o, pit_enable_o}));
endmodule

// File: rtl/lir_route_matrix.sv
module lir_route_matrix #(
  parameter int unsigned NUM_TIMERS = lir_pkg::DEF_NUM_TIMERS,
  parameter int unsigned NUM_LINES  = lir_pkg::DEF_NUM_LINES,
  parameter int unsigned ROUTE_W    = lir_pkg::DEF_ROUTE_W,
  parameter int unsigned T0_LINE    = lir_pkg::DEF_T0_LINE,
  parameter int unsigned T1_LINE    = lir_pkg::DEF_T1_LINE
) (
  input  logic                          legacy_i,
  input  logic [NUM_TIMERS-1:0]         tmr_irq_i,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route_i,
  output logic [NUM_LINES-1:0]          lines_o
);
  logic [NUM_LINES-1:0] hit [NUM_TIMERS];

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic [ROUTE_W-1:0] sel;
    if (t == 0) begin : g_fix0
      assign sel = legacy_i ? ROUTE_W'(T0_LINE) : tmr_route_i[t*ROUTE_W +: ROUTE_W];
    end else if (t == 1) begin : g_fix1
      assign sel = legacy_i ? ROUTE_W'(T1_LINE) : tmr_route_i[t*ROUTE_W +: ROUTE_W];
    end else begin : g_free
      assign sel = tmr_route_i[t*ROUTE_W +: ROUTE_W];
    end
    always_comb begin
      hit[t] = '0;
      for (int l = 0; l < NUM_LINES; l++) begin
        if (tmr_irq_i[t] && (32'(sel) == l)) hit[t][l] = 1'b1;
      end
    end
  end

  always_comb begin
    lines_o = '0;
    for (int t = 0; t < NUM_TIMERS; t++) lines_o |= hit[t];
  end
endmodule

// File: rtl/lir_rtc_gate.sv
module lir_rtc_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rtc_level_i,
  input  logic legacy_q_i,
  output logic rtc_stored_o,
  output logic rtc_line_o
);
  logic rtc_q;

  // level is recorded in every mode, so leaving legacy mode replays it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rtc_q <= 1'b0;
    else         rtc_q <= rtc_level_i;
  end

  assign rtc_stored_o = rtc_q;
  assign rtc_line_o   = rtc_q & ~legacy_q_i;
endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router #(
  parameter int unsigned NUM_TIMERS = lir_pkg::DEF_NUM_TIMERS,
  parameter int unsigned NUM_LINES  = lir_pkg::DEF_NUM_LINES,
  parameter int unsigned ROUTE_W    = lir_pkg::DEF_ROUTE_W,
  parameter int unsigned T0_LINE    = lir_pkg::DEF_T0_LINE,
  parameter int unsigned T1_LINE    = lir_pkg::DEF_T1_LINE,
  parameter int unsigned RTC_LINE   = lir_pkg::DEF_RTC_LINE
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic                          cfg_legacy_i,
  input  logic [NUM_TIMERS-1:0]         tmr_irq_i,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route_i,
  input  logic                          rtc_level_i,
  output logic [NUM_LINES-1:0]          irq_o,
  output logic                          legacy_o,
  output logic                          rtc_masked_o,
  output logic                          pit_disable_o,
  output logic                          pit_enable_o
);
  localparam logic [NUM_LINES-1:0] RTC_MASK = NUM_LINES'(1) << RTC_LINE;

  logic                 legacy_d, legacy_q;
  logic                 rtc_stored, rtc_line;
  logic [NUM_LINES-1:0] tmr_lines_d, tmr_lines_q;

  lir_cfg_ctrl i_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_legacy_i,
    .legacy_d_o    (legacy_d),
    .legacy_q_o    (legacy_q),
    .pit_disable_o (pit_disable_o),
    .pit_enable_o  (pit_enable_o)
  );

  lir_route_matrix #(
    .NUM_TIMERS (NUM_TIMERS), .NUM_LINES (NUM_LINES), .ROUTE_W (ROUTE_W),
    .T0_LINE (T0_LINE), .T1_LINE (T1_LINE)
  ) i_matrix (
    .legacy_i    (legacy_d),
    .tmr_irq_i   (tmr_irq_i),
    .tmr_route_i (tmr_route_i),
    .lines_o     (tmr_lines_d)
  );

  lir_rtc_gate i_rtc (
    .clk_i, .rst_ni, .rtc_level_i,
    .legacy_q_i   (legacy_q),
    .rtc_stored_o (rtc_stored),
    .rtc_line_o   (rtc_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_lines_q <= '0;
    else         tmr_lines_q <= tmr_lines_d;
  end

  assign irq_o        = tmr_lines_q | (rtc_line ? RTC_MASK : '0);
  assign legacy_o     = legacy_q;
  assign rtc_masked_o = legacy_q;

  a_r1_t0_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_d && tmr_irq_i[0]) |=> irq_o[T0_LINE]);
  if (NUM_TIMERS > 1) begin : g_t1_chk
    a_r2_t1_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (legacy_d && tmr_irq_i[1]) |=> irq_o[T1_LINE]);
  end
  a_r6_rtc_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_o && !tmr_lines_q[RTC_LINE]) |-> !irq_o[RTC_LINE]);
  a_r5_rtc_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_o && !tmr_lines_q[RTC_LINE]) |-> (irq_o[RTC_LINE] == rtc_stored));
  a_r5_rtc_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rtc_stored == $past(rtc_level_i)));
  a_r11_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && !legacy_o && !pit_disable_o && !pit_enable_o));
endmodule

// File: tb/test_legacy_irq_router.sv
module test_legacy_irq_router;
  localparam int NT = 4, NL = 24, RW = 5;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            we = 1'b0, leg = 1'b0, rtc = 1'b0;
  logic [NT-1:0]   tirq = '0;
  logic [NT*RW-1:0] troute = '0;
  logic [NL-1:0]   irq;
  logic            legacy, masked, dis, en;

  int errors = 0, checks = 0;
  bit legacy_m = 1'b0;

  typedef struct { logic [NL-1:0] irq; logic legacy, masked, dis, en; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  legacy_irq_router i_legacy_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_legacy_i(leg),
    .tmr_irq_i(tirq), .tmr_route_i(troute), .rtc_level_i(rtc),
    .irq_o(irq), .legacy_o(legacy), .rtc_masked_o(masked),
    .pit_disable_o(dis), .pit_enable_o(en)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus at negedge, push the model result
  task automatic step(string tag, bit w, bit l, logic [NT-1:0] ti,
                      logic [NT*RW-1:0] tr, bit r);
    exp_t e;
    bit nl;
    @(negedge clk);
    we = w; leg = l; tirq = ti; troute = tr; rtc = r;
    nl = w ? l : legacy_m;
    e.irq = '0;
    for (int t = 0; t < NT; t++) begin
      int ln;
      ln = int'(tr[t*RW +: RW]);
      if (nl && t == 0) ln = 0;
      if (nl && t == 1) ln = 8;
      if (ti[t] && ln < NL) e.irq[ln] = 1'b1;
    end
    if (r && !nl) e.irq[8] = 1'b1;
    e.legacy = nl; e.masked = nl;
    e.dis = w && l && !legacy_m;
    e.en  = w && !l && legacy_m;
    e.tag = tag;
    legacy_m = nl;
    q.push_back(e);
  endtask

  // monitor: compare one cycle after each pushed item
  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " irq"},    32'(irq),    32'(e.irq));
      check({e.tag, " legacy"}, 32'(legacy), 32'(e.legacy));
      check({e.tag, " masked"}, 32'(masked), 32'(e.masked));
      check({e.tag, " dis"},    32'(dis),    32'(e.dis));
      check({e.tag, " en"},     32'(en),     32'(e.en));
    end
  end

  function automatic logic [NT*RW-1:0] rt(int a, int b, int c, int d);
    return {RW'(d), RW'(c), RW'(b), RW'(a)};
  endfunction

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rtc = 1'b1; tirq = '1;
    #23;
    check("R11 reset irq", 32'(irq), 0);
    check("R11 reset strobes", 32'({legacy, dis, en}), 0);
    @(negedge clk); rst_n = 1'b1; rtc = 1'b0; tirq = '0;
    // R3 R10 normal routing
    step("R3 routes", 0, 0, 4'b1111, rt(3, 5, 10, 23), 0);
    step("R3 out of range", 0, 0, 4'b1111, rt(24, 31, 30, 2), 0);
    // R4 shared line
    step("R4 one of two", 0, 0, 4'b0001, rt(7, 7, 9, 9), 0);
    step("R4 both", 0, 0, 4'b1111, rt(7, 7, 9, 9), 0);
    // R5 pass-through
    step("R5 rtc pass", 0, 0, 4'b0000, rt(1, 2, 3, 4), 1);
    step("R5 rtc plus t0", 0, 0, 4'b0001, rt(8, 2, 3, 4), 1);
    // R7 R6 enter legacy with clock high
    step("R7 enter", 1, 1, 4'b0000, rt(12, 15, 4, 6), 1);
    step("R1 t0 fixed", 0, 0, 4'b0001, rt(12, 15, 4, 6), 1);
    step("R2 t1 fixed", 0, 0, 4'b0010, rt(12, 15, 4, 6), 1);
    step("R3 t2 legacy", 0, 0, 4'b0100, rt(12, 15, 4, 6), 1);
    step("R9 same write", 1, 1, 4'b0000, rt(12, 15, 4, 6), 0);
    step("R5 rtc low in legacy", 0, 0, 4'b0000, rt(12, 15, 4, 6), 0);
    step("R6 rtc high in legacy", 0, 0, 4'b0000, rt(12, 15, 4, 6), 1);
    step("R8 exit replay", 1, 0, 4'b0000, rt(12, 15, 4, 6), 1);
    step("R9 same write clear", 1, 0, 4'b0001, rt(12, 15, 4, 6), 1);
    step("R9 idle", 0, 1, 4'b0000, rt(12, 15, 4, 6), 0);
    step("R7 enter low", 1, 1, 4'b0011, rt(12, 15, 4, 6), 0);
    step("R8 exit low", 1, 0, 4'b0011, rt(12, 15, 4, 6), 0);
    step("R7 reenter", 1, 1, 4'b0000, rt(0, 0, 0, 0), 1);
    @(negedge clk); we = 0; tirq = '0;
    @(negedge clk);
    // R11 reset mid-run while in legacy mode
    rst_n = 1'b0; rtc = 1'b1; #1;
    check("R11 mid reset", 32'({irq, legacy, masked}), 0);
    @(negedge clk); rst_n = 1'b1; legacy_m = 1'b0; rtc = 1'b0;
    step("R11 after reset", 0, 0, 4'b0000, rt(0, 0, 0, 0), 0);
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule